// File: doc/BRIEF.md
# Horizontal Blanking Window and Transfer-Clock Masking

This block times a horizontal blanking window on each video line and gates the four horizontal transfer clocks of an image sensor while that window is open. A pixel counter restarts on each horizontal sync pulse and advances once per pixel clock. Four blanking sequences are held in a small register bank. Each sequence has a start position, an end position and a mask-polarity bit. The sequence that a line uses is chosen by a select input, and that select is captured at the start of the line.

While blanking is open, the four clocks are held at fixed levels. The mask bit sets the polarity of the odd clocks, and the even clocks take the opposite level. While blanking is closed, the odd clocks follow a free-running source clock and the even clocks follow its inverse. The window has no polarity setting of its own. It is always closed when a line begins, unless its start position is zero. When the end position is not greater than the start position, the window stays open until the next sync.

Top module: `hblank_gen`

## Requirements
- R1: After reset, every sequence holds start 4095, end 0 and mask 0, the pixel count is 0, hblank is 0 and the clocks pass through.
- R2: A cycle with hsync high loads count 0 at the next clock. Each later clock adds one, and the count saturates at 4095.
- R3: When end > start, hblank is 1 exactly while start <= count < end.
- R4: When end <= start, hblank is 1 from count == start until the next hsync.
- R5: With mask bit 1 and hblank 1, h1 = h3 = 0 and h2 = h4 = 1.
- R6: With mask bit 0 and hblank 1, h1 = h3 = 1 and h2 = h4 = 0.
- R7: With hblank 0, h1 and h3 equal src_hclk and h2 and h4 equal its inverse, in the same cycle.
- R8: seq_sel is captured only in an hsync cycle. A change to it in the middle of a line has no effect until the next sync.
- R9: A write takes effect at the next clock. It is selected by wr_seq, and wr_field chooses what it updates: 0 = start (wr_data), 1 = end (wr_data), 2 = mask (wr_data bit 0), 3 = nothing. A write to the active sequence in the middle of a line changes the window from the next count onward.
- R10: The four sequences are stored independently. A line run on any of them shows that sequence's own window and mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hsync | input | 1 | Line start; restarts the pixel count |
| seq_sel | input | 2 | Blanking sequence chosen for the next line |
| src_hclk | input | 1 | Free-running source horizontal clock |
| wr_en | input | 1 | Register write strobe |
| wr_seq | input | 2 | Sequence index that the write targets |
| wr_field | input | 2 | Field code: 0 start, 1 end, 2 mask, 3 none |
| wr_data | input | 12 | Write data (the mask uses bit 0) |
| hblank | output | 1 | Blanking window active |
| h1 | output | 1 | Horizontal clock phase 1 |
| h2 | output | 1 | Horizontal clock phase 2 |
| h3 | output | 1 | Horizontal clock phase 3 |
| h4 | output | 1 | Horizontal clock phase 4 |

## Verification
The pixel count is valid one clock after hsync, so the bench takes sample k at the k-th falling edge after the sync edge. hblank is a combinational function of that registered count and the active sequence, so it is checked in the same half cycle. The h outputs depend on src_hclk without a register in between, so the bench flips the source on each falling edge and compares a few nanoseconds later. Register writes and select changes land on the next rising edge, so their effect is checked from the sample that follows that edge.

// File: rtl/hbk_pkg.sv
package hbk_pkg;

    // Field codes carried on the write port
    typedef enum logic [1:0] {
        FLD_START = 2'd0,
        FLD_END   = 2'd1,
        FLD_MASK  = 2'd2,
        FLD_NONE  = 2'd3
    } hbk_field_e;

    // Window rule shared by the compare logic
    function automatic logic in_window(input int unsigned cnt,
                                       input int unsigned t_on,
                                       input int unsigned t_off);
        logic past_on;
        past_on = (cnt >= t_on);
        if (t_off > t_on) return past_on && (cnt < t_off);
        return past_on;
    endfunction

endpackage

// File: rtl/hbk_seq_bank.sv
module hbk_seq_bank
    import hbk_pkg::*;
#(
    parameter int NSEQ  = 4,
    parameter int POS_W = 12,
    localparam int SEL_W = (NSEQ > 1) ? $clog2(NSEQ) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_seq,
    input  logic [1:0]       wr_field,
    input  logic [POS_W-1:0] wr_data,
    input  logic [SEL_W-1:0] rd_sel,
    output logic [POS_W-1:0] rd_on,
    output logic [POS_W-1:0] rd_off,
    output logic             rd_mask
);

    typedef struct packed {
        logic [POS_W-1:0] t_on;
        logic [POS_W-1:0] t_off;
        logic             mask;
    } seq_t;

    localparam seq_t SEQ_RST = '{t_on: {POS_W{1'b1}}, t_off: '0, mask: 1'b0};

    seq_t ent_arr [NSEQ];

    for (genvar s = 0; s < NSEQ; s++) begin : g_ent
        seq_t ent_d, ent_q;
        logic hit;

        assign hit = wr_en && (wr_seq == SEL_W'(s));

        always_comb begin
            ent_d = ent_q;
            if (hit) begin
                unique case (hbk_field_e'(wr_field))
                    FLD_START: ent_d.t_on  = wr_data;
                    FLD_END:   ent_d.t_off = wr_data;
                    FLD_MASK:  ent_d.mask  = wr_data[0];
                    FLD_NONE:  ent_d       = ent_q;
                endcase
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ent_q <= SEQ_RST;
            else        ent_q <= ent_d;
        end

        assign ent_arr[s] = ent_q;
    end

    seq_t rd_ent;
    always_comb begin
        rd_ent = SEQ_RST;
        for (int s = 0; s < NSEQ; s++) begin
            if (rd_sel == SEL_W'(s)) rd_ent = ent_arr[s];
        end
    end

    assign rd_on   = rd_ent.t_on;
    assign rd_off  = rd_ent.t_off;
    assign rd_mask = rd_ent.mask;

endmodule

// File: rtl/hbk_line_cnt.sv
module hbk_line_cnt #(
    parameter int POS_W = 12,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hsync,
    input  logic [SEL_W-1:0] seq_sel,
    output logic [POS_W-1:0] cnt,
    output logic [SEL_W-1:0] act_sel
);

    localparam logic [POS_W-1:0] CNT_MAX = {POS_W{1'b1}};

    typedef struct packed {
        logic [POS_W-1:0] cnt;
        logic [SEL_W-1:0] sel;
    } lc_state_t;

    lc_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (hsync) begin
            st_d.cnt = '0;
            st_d.sel = seq_sel;
        end else if (st_q.cnt != CNT_MAX) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt     = st_q.cnt;
    assign act_sel = st_q.sel;

endmodule

// File: rtl/hbk_hmask.sv
module hbk_hmask
    import hbk_pkg::*;
#(
    parameter int POS_W = 12,
    parameter int NPH   = 4
) (
    input  logic [POS_W-1:0] cnt,
    input  logic [POS_W-1:0] t_on,
    input  logic [POS_W-1:0] t_off,
    input  logic             mask,
    input  logic             src_hclk,
    output logic             blank,
    output logic [NPH-1:0]   hph
);

    assign blank = in_window(int'(cnt), int'(t_on), int'(t_off));

    // Index 0,2 are the odd-numbered clocks (in phase with the source)
    for (genvar p = 0; p < NPH; p++) begin : g_ph
        if ((p % 2) == 0) begin : g_inph
            assign hph[p] = blank ? ~mask : src_hclk;
        end else begin : g_antiph
            assign hph[p] = blank ? mask : ~src_hclk;
        end
    end

endmodule

// File: rtl/hblank_gen.sv
module hblank_gen #(
    parameter int NSEQ  = 4,
    parameter int POS_W = 12,
    localparam int SEL_W = (NSEQ > 1) ? $clog2(NSEQ) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hsync,
    input  logic [SEL_W-1:0] seq_sel,
    input  logic             src_hclk,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_seq,
    input  logic [1:0]       wr_field,
    input  logic [POS_W-1:0] wr_data,
    output logic             hblank,
    output logic             h1,
    output logic             h2,
    output logic             h3,
    output logic             h4
);

    localparam int NPH = 4;

    logic [POS_W-1:0] line_cnt;
    logic [SEL_W-1:0] act_sel;
    logic [POS_W-1:0] act_on;
    logic [POS_W-1:0] act_off;
    logic             act_mask;
    logic [NPH-1:0]   hph;

    hbk_line_cnt #(.POS_W(POS_W), .SEL_W(SEL_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .hsync   (hsync),
        .seq_sel (seq_sel),
        .cnt     (line_cnt),
        .act_sel (act_sel)
    );

    hbk_seq_bank #(.NSEQ(NSEQ), .POS_W(POS_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_seq   (wr_seq),
        .wr_field (wr_field),
        .wr_data  (wr_data),
        .rd_sel   (act_sel),
        .rd_on    (act_on),
        .rd_off   (act_off),
        .rd_mask  (act_mask)
    );

    hbk_hmask #(.POS_W(POS_W), .NPH(NPH)) u_mask (
        .cnt      (line_cnt),
        .t_on     (act_on),
        .t_off    (act_off),
        .mask     (act_mask),
        .src_hclk (src_hclk),
        .blank    (hblank),
        .hph      (hph)
    );

    assign h1 = hph[0];
    assign h2 = hph[1];
    assign h3 = hph[2];
    assign h4 = hph[3];

endmodule

// File: rtl/hbk_chk.sv
module hbk_chk #(
    parameter int POS_W = 12,
    parameter int SEL_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hsync,
    input logic [SEL_W-1:0] seq_sel,
    input logic             src_hclk,
    input logic             hblank,
    input logic             h1,
    input logic             h2,
    input logic             h3,
    input logic             h4,
    input logic [POS_W-1:0] line_cnt,
    input logic [SEL_W-1:0] act_sel,
    input logic             act_mask
);

    localparam logic [POS_W-1:0] CNT_MAX = {POS_W{1'b1}};

    // R2
    cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hsync |=> (line_cnt == '0));

    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hsync && line_cnt != CNT_MAX) |=> (line_cnt == $past(line_cnt) + 1'b1));

    // R2
    cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hsync && line_cnt == CNT_MAX) |=> (line_cnt == CNT_MAX));

    // R8
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hsync |=> $stable(act_sel));

    // R8
    sel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hsync |=> (act_sel == $past(seq_sel)));

    // R5
    mask_hi_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hblank && act_mask) |-> (!h1 && h2 && !h3 && h4));

    // R6
    mask_lo_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hblank && !act_mask) |-> (h1 && !h2 && h3 && !h4));

    // R7
    pass_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hblank |-> (h1 == src_hclk && h3 == src_hclk && h2 == !src_hclk && h4 == !src_hclk));

endmodule

bind hblank_gen hbk_chk #(.POS_W(POS_W), .SEL_W(SEL_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .hsync    (hsync),
    .seq_sel  (seq_sel),
    .src_hclk (src_hclk),
    .hblank   (hblank),
    .h1       (h1),
    .h2       (h2),
    .h3       (h3),
    .h4       (h4),
    .line_cnt (line_cnt),
    .act_sel  (act_sel),
    .act_mask (act_mask)
);

// File: tb/tb_hblank_gen.sv
module tb_hblank_gen;

    localparam int CNT_MAX = 4095;
    localparam int NVEC    = 6;
    localparam int SCAN    = 40;
    // each vector: sequence, start, end, mask
    localparam int VEC [NVEC][4] = '{
        '{0,  5, 12, 1},
        '{1,  0,  3, 0},
        '{2, 10,  4, 1},
        '{3,  7,  7, 0},
        '{0, 20, 30, 0},
        '{1,  1,  2, 1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hsync = 1'b0;
    logic [1:0] seq_sel = '0;
    logic       src_hclk = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_seq = '0;
    logic [1:0] wr_field = '0;
    logic [11:0] wr_data = '0;
    logic       hblank, h1, h2, h3, h4;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    hblank_gen dut (
        .clk(clk), .rst_n(rst_n), .hsync(hsync), .seq_sel(seq_sel),
        .src_hclk(src_hclk), .wr_en(wr_en), .wr_seq(wr_seq),
        .wr_field(wr_field), .wr_data(wr_data),
        .hblank(hblank), .h1(h1), .h2(h2), .h3(h3), .h4(h4)
    );

    function automatic bit exp_win(int k, int t_on, int t_off);
        int kk;
        kk = (k > CNT_MAX) ? CNT_MAX : k;
        if (t_off > t_on) return (kk >= t_on) && (kk < t_off);
        return kk >= t_on;
    endfunction

    task automatic check_pix(string req, int k, int t_on, int t_off, int m);
        bit eb;
        logic [3:0] eh, ah;
        eb = exp_win(k, t_on, t_off);
        if (eb) eh = m[0] ? 4'b1010 : 4'b0101;
        else    eh = {~src_hclk, src_hclk, ~src_hclk, src_hclk};
        ah = {h4, h3, h2, h1};
        checks++;
        if (hblank !== eb || ah !== eh) begin
            errors++;
            $display("FAIL %s pix %0d: hblank=%b h4..h1=%b expected hblank=%b h4..h1=%b",
                     req, k, hblank, ah, eb, eh);
        end
    endtask

    task automatic wr_cfg(int s, int f, int d);
        @(negedge clk);
        wr_en = 1'b1; wr_seq = 2'(s); wr_field = 2'(f); wr_data = 12'(d);
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic start_line(int s);
        @(negedge clk);
        seq_sel = 2'(s); hsync = 1'b1;
        @(posedge clk);
        @(negedge clk);
        hsync = 1'b0; src_hclk = ~src_hclk;
        #5;
    endtask

    task automatic next_pix();
        @(posedge clk);
        @(negedge clk);
        src_hclk = ~src_hclk;
        #5;
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #5;
        // R1: reset defaults start=4095 end=0, count 0 -> closed, pass-through
        for (int k = 0; k < 4; k++) begin
            check_pix("R1", k, CNT_MAX, 0, 0);
            next_pix();
        end

        // R3 R4 R5 R6 R7 R10: table walk
        for (int v = 0; v < NVEC; v++) begin
            wr_cfg(VEC[v][0], 0, VEC[v][1]);
            wr_cfg(VEC[v][0], 1, VEC[v][2]);
            wr_cfg(VEC[v][0], 2, VEC[v][3]);
            start_line(VEC[v][0]);
            for (int k = 0; k < SCAN; k++) begin
                check_pix("R3/R4/R5/R6/R7/R10", k, VEC[v][1], VEC[v][2], VEC[v][3]);
                next_pix();
            end
        end
        // table leaves seq0=(20,30,0) seq1=(1,2,1) seq2=(10,4,1) seq3=(7,7,0)

        // R8: change select mid-line; window must stay that of seq0
        start_line(0);
        for (int k = 0; k < SCAN; k++) begin
            if (k == 3) seq_sel = 2'd2;
            check_pix("R8", k, 20, 30, 0);
            next_pix();
        end
        // next line picks up seq2
        start_line(2);
        for (int k = 0; k < 16; k++) begin
            check_pix("R8", k, 10, 4, 1);
            next_pix();
        end

        // R9: field code 3 and writes to other sequences leave seq1 unchanged
        wr_cfg(1, 0, 10);
        wr_cfg(1, 1, 20);
        wr_cfg(1, 2, 0);
        wr_cfg(1, 3, 0);
        wr_cfg(0, 0, 0);
        wr_cfg(2, 1, 4095);
        start_line(1);
        for (int k = 0; k < 26; k++) begin
            check_pix("R9", k, 10, 20, 0);
            next_pix();
        end

        // R9: write to the active sequence mid-line acts from the next count
        wr_cfg(3, 0, 30);
        wr_cfg(3, 1, 40);
        wr_cfg(3, 2, 1);
        start_line(3);
        for (int k = 0; k < 6; k++) begin
            check_pix("R9", k, 30, 40, 1);
            next_pix();
        end
        // now at pixel 6; write lands at the next edge (pixel 7)
        wr_en = 1'b1; wr_seq = 2'd3; wr_field = 2'd0; wr_data = 12'd8;
        next_pix();
        wr_en = 1'b0;
        for (int k = 7; k < 14; k++) begin
            check_pix("R9", k, 8, 40, 1);
            next_pix();
        end

        // R2 R4: saturation at 4095 keeps an open-ended window open
        wr_cfg(2, 0, 4090);
        wr_cfg(2, 1, 0);
        wr_cfg(2, 2, 0);
        start_line(2);
        for (int k = 0; k < 4110; k++) begin
            if (k >= 4080) check_pix("R2", k, 4090, 0, 0);
            next_pix();
        end

        // R2 R3: window closing at 4095 stays closed after saturation
        wr_cfg(2, 0, 4093);
        wr_cfg(2, 1, 4095);
        start_line(2);
        for (int k = 0; k < 4105; k++) begin
            if (k >= 4088) check_pix("R2", k, 4093, 4095, 0);
            next_pix();
        end

        // R2: hsync restarts count mid-line
        start_line(0);
        for (int k = 0; k < 6; k++) next_pix();
        start_line(0);
        for (int k = 0; k < 3; k++) begin
            check_pix("R2", k, 0, 30, 0);
            next_pix();
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule